// File: doc/BRIEF.md
# SMI Entry and Exit Sequencer

This block decides when a processor core enters and leaves system management mode. It watches the active-low SMI pin for a falling edge and checks that the management memory region is set up. It also holds the request off while a configuration index/data access is outstanding. When all of these allow it, the block raises a one-cycle entry pulse together with a request for an acknowledge bus cycle, and it marks the core as being in service.

A resume pulse ends the service routine. It raises a second acknowledge request and clears the in-service flag. The flag that tags outgoing bus requests as management-memory accesses stays up until the bus reports that the last management-memory cycle has finished.

The block also arbitrates non-maskable interrupts against SMI. SMI always wins. An NMI is held back during service unless the NMI enable bit is set. At most one extra SMI and one NMI are kept while they wait.

Top module: `smi_sequencer`

## Requirements
- R1: A falling edge on `smi_n` is detected through two synchroniser flops and a previous-sample flop, so `smm_enter` goes high after the third rising clock edge that follows the pin falling. Holding `smi_n` low never triggers a second entry.
- R2: An SMI is taken only when `rgn_size` is non-zero and `rgn_en` is 1. An edge that arrives while the region is off is dropped, and later enabling the region does not bring it back.
- R3: While `cfg_hold` is 1, a detected edge with the region enabled stays pending. It is taken on the first rising edge at which `cfg_hold` is 0.
- R4: On entry, `smm_enter` and `ack_req` are both high for exactly one cycle, and `smm_active` rises in that same cycle.
- R5: A one-cycle `rsm_pulse` during service gives one cycle of `ack_req` and drops `smm_active`, both after the rising edge that samples the pulse.
- R6: With `mode_enh` = 0, `smm_mem` is 1 for the whole of service whatever `rgn_hit` is. After resume it stays 1 until a rising edge samples `smm_bus_idle` = 1, and it is 0 after that edge.
- R7: With `mode_enh` = 1, `smm_mem` equals `rgn_hit` while in service or draining. Outside management mode `smm_mem` is 0.
- R8: During service, one more SMI edge is remembered and any further edges are lost. The remembered SMI enters one cycle after the drain completes.
- R9: `nmi_take` pulses for one cycle after the edge that samples an `nmi_req` pulse, provided the block is not in management mode or `nmi_en` is 1. Otherwise exactly one NMI is latched. It is delivered once `nmi_en` is 1, or one cycle after leaving management mode.
- R10: When an SMI entry and an NMI fall on the same edge, the SMI enters and the NMI is latched, not delivered.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smi_n | input | 1 | Asynchronous SMI request, falling-edge active |
| nmi_req | input | 1 | One-cycle NMI request |
| rsm_pulse | input | 1 | Resume instruction executed |
| smm_bus_idle | input | 1 | Last management-memory bus cycle has completed |
| mode_enh | input | 1 | 1 = memory flag follows region hit, 0 = flag held |
| nmi_en | input | 1 | Allow NMI during service |
| rgn_size | input | 4 | Management region size code, 0 = disabled |
| rgn_en | input | 1 | Management region enable |
| cfg_hold | input | 1 | Configuration index/data access outstanding |
| rgn_hit | input | 1 | Current request address lies in the management region |
| ack_req | output | 1 | Request an acknowledge bus cycle |
| smm_enter | output | 1 | Entry pulse |
| nmi_take | output | 1 | NMI delivered |
| smm_active | output | 1 | Service routine in progress |
| smm_mem | output | 1 | Tag for management-memory bus requests |

## Verification
An SMI entry and an NMI delivery can fall on the same clock edge. The bench provokes this by pulsing `nmi_req` in exactly the cycle in which the synchronised SMI edge becomes visible. It then expects the entry pulse without `nmi_take`, followed by a single delayed NMI delivery one cycle after the drain ends. A second collision occurs when the resume and a new SMI edge fall together during service. That case is judged by the remembered SMI entering straight after the drain.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SERVE = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       smi_pend;
        logic       enter;
        logic       ack;
    } ctrl_regs_t;

    typedef struct packed {
        logic pend;
        logic take;
    } nmi_regs_t;

endpackage

// File: rtl/smi_edge_sync.sv
module smi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d[0] = pin_n;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
        prev_d = sh_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sh_q[LAST];

    p_single_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/smi_ctrl.sv
module smi_ctrl
    import smi_seq_pkg::*;
#(
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_fall,
    input  logic              rsm_pulse,
    input  logic              bus_idle,
    input  logic [SIZE_W-1:0] rgn_size,
    input  logic              rgn_en,
    input  logic              cfg_hold,
    output logic              smi_win,
    output logic              in_smm,
    output logic              serving,
    output logic              enter,
    output logic              ack
);
    ctrl_regs_t r_d, r_q;
    logic       cfg_ok;
    logic       req;

    always_comb begin
        r_d     = r_q;
        r_d.enter = 1'b0;
        r_d.ack   = 1'b0;
        smi_win = 1'b0;
        cfg_ok  = (rgn_size != '0) && rgn_en;
        req     = smi_fall || r_q.smi_pend;
        case (r_q.st)
            SEQ_IDLE: begin
                if (req) begin
                    if (cfg_ok && !cfg_hold) begin
                        r_d.st       = SEQ_SERVE;
                        r_d.enter    = 1'b1;
                        r_d.ack      = 1'b1;
                        r_d.smi_pend = 1'b0;
                        smi_win      = 1'b1;
                    end else begin
                        r_d.smi_pend = cfg_ok;
                    end
                end
            end
            SEQ_SERVE: begin
                if (smi_fall) r_d.smi_pend = 1'b1;
                if (rsm_pulse) begin
                    r_d.st  = SEQ_DRAIN;
                    r_d.ack = 1'b1;
                end
            end
            SEQ_DRAIN: begin
                if (smi_fall) r_d.smi_pend = 1'b1;
                if (bus_idle) r_d.st = SEQ_IDLE;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, smi_pend: 1'b0, enter: 1'b0, ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_smm  = (r_q.st != SEQ_IDLE);
    assign serving = (r_q.st == SEQ_SERVE);
    assign enter   = r_q.enter;
    assign ack     = r_q.ack;

    p_entry_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enter |-> $past((rgn_size != '0) && rgn_en && !cfg_hold));

    p_entry_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enter |-> (ack && serving));

    p_resume_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serving) |-> ack);

endmodule

// File: rtl/smi_nmi_arb.sv
module smi_nmi_arb
    import smi_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic in_smm,
    input  logic nmi_en,
    input  logic smi_win,
    output logic nmi_take
);
    nmi_regs_t n_d, n_q;
    logic      ev;
    logic      blocked;

    always_comb begin
        ev       = nmi_req || n_q.pend;
        blocked  = (in_smm && !nmi_en) || smi_win;
        n_d.take = ev && !blocked;
        n_d.pend = ev && blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{pend: 1'b0, take: 1'b0};
        end else begin
            n_q <= n_d;
        end
    end

    assign nmi_take = n_q.take;

    p_nmi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |-> $past(!in_smm || nmi_en));

    p_nmi_loses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smi_win |=> !nmi_take);

endmodule

// File: rtl/smi_sequencer.sv
module smi_sequencer
    import smi_seq_pkg::*;
#(
    parameter int SIZE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_n,
    input  logic              nmi_req,
    input  logic              rsm_pulse,
    input  logic              smm_bus_idle,
    input  logic              mode_enh,
    input  logic              nmi_en,
    input  logic [SIZE_W-1:0] rgn_size,
    input  logic              rgn_en,
    input  logic              cfg_hold,
    input  logic              rgn_hit,
    output logic              ack_req,
    output logic              smm_enter,
    output logic              nmi_take,
    output logic              smm_active,
    output logic              smm_mem
);
    logic smi_fall;
    logic smi_win;
    logic in_smm;

    smi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (smi_n),
        .fall  (smi_fall)
    );

    smi_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smi_fall  (smi_fall),
        .rsm_pulse (rsm_pulse),
        .bus_idle  (smm_bus_idle),
        .rgn_size  (rgn_size),
        .rgn_en    (rgn_en),
        .cfg_hold  (cfg_hold),
        .smi_win   (smi_win),
        .in_smm    (in_smm),
        .serving   (smm_active),
        .enter     (smm_enter),
        .ack       (ack_req)
    );

    smi_nmi_arb u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .in_smm   (in_smm),
        .nmi_en   (nmi_en),
        .smi_win  (smi_win),
        .nmi_take (nmi_take)
    );

    // Compatible mode tags every access; enhanced mode tags region hits only.
    assign smm_mem = in_smm && (!mode_enh || rgn_hit);

    p_compat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && !mode_enh) |-> smm_mem);

    p_mem_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(smm_mem) && !mode_enh && $past(!mode_enh)) |-> $past(smm_bus_idle));

    p_smi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(smm_enter && nmi_take));

endmodule

// File: tb/smi_sequencer_bench.sv
module smi_sequencer_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smi_n = 1'b1, nmi_req = 1'b0, rsm_pulse = 1'b0, smm_bus_idle = 1'b0;
    logic       mode_enh = 1'b0, nmi_en = 1'b0, rgn_en = 1'b0, cfg_hold = 1'b0, rgn_hit = 1'b0;
    logic [3:0] rgn_size = 4'd0;
    logic       ack_req, smm_enter, nmi_take, smm_active, smm_mem;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_sequencer u_smi_sequencer (
        .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .nmi_req(nmi_req),
        .rsm_pulse(rsm_pulse), .smm_bus_idle(smm_bus_idle), .mode_enh(mode_enh),
        .nmi_en(nmi_en), .rgn_size(rgn_size), .rgn_en(rgn_en), .cfg_hold(cfg_hold),
        .rgn_hit(rgn_hit), .ack_req(ack_req), .smm_enter(smm_enter),
        .nmi_take(nmi_take), .smm_active(smm_active), .smm_mem(smm_mem)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_now();
        smi_n = 1'b0;
        step(3);
        step(1);
    endtask

    task automatic leave_now();
        rsm_pulse = 1'b1;
        step(1);
        rsm_pulse = 1'b0;
        smm_bus_idle = 1'b1;
        step(1);
        smm_bus_idle = 1'b0;
    endtask

    task automatic raise_pin();
        smi_n = 1'b1;
        step(3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11 reset state
        chk("R11 outputs", {ack_req, smm_enter, nmi_take, smm_active, smm_mem}, 5'b0);

        // R2 sweep of size code and enable
        for (int sz = 0; sz < 16; sz++) begin
            for (int en = 0; en < 2; en++) begin
                rgn_size = sz[3:0];
                rgn_en   = en[0];
                smi_n    = 1'b0;
                step(3);
                chk($sformatf("R2 gate sz=%0d en=%0d", sz, en), smm_enter,
                    (sz != 0 && en == 1) ? 1 : 0);
                if (sz != 0 && en == 1) begin
                    step(1);
                    leave_now();
                end
                raise_pin();
            end
        end

        // R2 dropped edge does not come back
        rgn_size = 4'd0; rgn_en = 1'b1;
        smi_n = 1'b0; step(3);
        rgn_size = 4'd5; step(4);
        chk("R2 dropped edge", smm_active, 0);
        raise_pin();

        // R1 latency and level insensitivity, R4 entry pulse shape
        smi_n = 1'b0; step(2);
        chk("R1 not yet", smm_enter, 0);
        step(1);
        chk("R4 enter", smm_enter, 1);
        chk("R4 ack", ack_req, 1);
        chk("R4 active", smm_active, 1);
        step(1);
        chk("R4 enter one cycle", {smm_enter, ack_req}, 0);
        leave_now();
        step(5);
        chk("R1 held low no retrigger", smm_active, 0);
        raise_pin();

        // R3 configuration hold-off
        cfg_hold = 1'b1; smi_n = 1'b0; step(5);
        chk("R3 deferred", smm_active, 0);
        cfg_hold = 1'b0; step(1);
        chk("R3 taken after hold", smm_enter, 1);
        step(1); leave_now(); raise_pin();

        // R5 and R6 compatible mode
        mode_enh = 1'b0;
        enter_now();
        for (int h = 0; h < 2; h++) begin
            rgn_hit = h[0]; #1;
            chk($sformatf("R6 held hit=%0d", h), smm_mem, 1);
        end
        rsm_pulse = 1'b1; step(1); rsm_pulse = 1'b0;
        chk("R5 resume ack", ack_req, 1);
        chk("R5 active drops", smm_active, 0);
        chk("R6 mem during drain", smm_mem, 1);
        step(3);
        chk("R6 mem waits bus", smm_mem, 1);
        chk("R5 ack one cycle", ack_req, 0);
        smm_bus_idle = 1'b1; step(1); smm_bus_idle = 1'b0;
        chk("R6 mem released", smm_mem, 0);
        rgn_hit = 1'b0;
        raise_pin();

        // R7 enhanced mode
        mode_enh = 1'b1; rgn_hit = 1'b1; #1;
        chk("R7 idle no mem", smm_mem, 0);
        enter_now();
        for (int h = 0; h < 2; h++) begin
            rgn_hit = h[0]; #1;
            chk($sformatf("R7 follow hit=%0d", h), smm_mem, h);
        end
        leave_now();
        mode_enh = 1'b0; rgn_hit = 1'b0;
        raise_pin();

        // R8 one extra SMI remembered
        enter_now();
        raise_pin();
        smi_n = 1'b0; step(3); raise_pin();
        smi_n = 1'b0; step(3); raise_pin();
        chk("R8 still serving", smm_active, 1);
        leave_now();
        chk("R8 left", smm_active, 0);
        step(1);
        chk("R8 pending entered", smm_enter, 1);
        step(1); leave_now(); step(5);
        chk("R8 extra lost", smm_active, 0);

        // R9 NMI masking and latching
        nmi_req = 1'b1; step(1); nmi_req = 1'b0;
        chk("R9 unmasked take", nmi_take, 1);
        step(1);
        chk("R9 take one cycle", nmi_take, 0);
        enter_now();
        for (int k = 0; k < 2; k++) begin
            nmi_req = 1'b1; step(1); nmi_req = 1'b0;
            chk("R9 masked", nmi_take, 0);
            step(1);
        end
        nmi_en = 1'b1; step(1);
        chk("R9 released by enable", nmi_take, 1);
        step(1);
        chk("R9 only one latched", nmi_take, 0);
        nmi_en = 1'b0;
        nmi_req = 1'b1; step(1); nmi_req = 1'b0;
        leave_now();
        chk("R9 waits exit", nmi_take, 0);
        step(1);
        chk("R9 after exit", nmi_take, 1);
        raise_pin();

        // R10 SMI and NMI on the same edge
        smi_n = 1'b0; step(2);
        nmi_req = 1'b1; step(1); nmi_req = 1'b0;
        chk("R10 smi enters", smm_enter, 1);
        chk("R10 nmi held", nmi_take, 0);
        step(1);
        chk("R10 nmi still held", nmi_take, 0);
        leave_now();
        chk("R10 not at exit edge", nmi_take, 0);
        step(1);
        chk("R10 nmi delivered", nmi_take, 1);
        raise_pin();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule